// File: doc/BRIEF.md
# Reset-Sampled Clock Configuration Controller

This block fixes the power-on clock setup of a chip from two mode-strap pins and then generates the slow timing enables that the real-time/periodic timer and the timebase run on. The straps are sampled only while the power-on reset is asserted. The value present in the last reset cycle is held until the next power-on reset. A hard reset on its own does not resample them. This matters for wake-up sequences, where the multiplier and timer clocking must survive the reset.

From the held strap code the block derives the reference-source and reference-frequency indications, the multiplier-plus-one value and the timebase divide ratio. It also loads four software override fields with their power-on defaults: timer clock source, timer slow divide, timebase source and system clock divider. Software can later rewrite these fields through a one-cycle write strobe. Two tick dividers turn the selected source ticks into one-cycle enable pulses. A counter restarts whenever its divide ratio changes.

Top module: `clkcfg_ctrl`

## Requirements
- R1: While `por` is high the strap pair is captured on every clock edge. After `por` falls, the strap-derived outputs (`ref_is_ext`, `ref_is_4m`, `mf_plus1`, `tb_div`) keep the value captured in the last `por` cycle, whatever the strap pins do.
- R2: `hrst` high with `por` low leaves every strap-derived output and all four override fields unchanged, and a write strobe during `hrst` is ignored.
- R3: `ref_is_ext` equals the captured `strap_src` (1 = external clock pin, 0 = on-chip oscillator). `ref_is_4m` equals the captured `strap_freq` (1 = 4 MHz reference, 0 = 32 kHz or one-to-one).
- R4: The strap code is {`strap_src`,`strap_freq`}. Code 00 gives `mf_plus1`=513 and `tb_div`=4. Codes 01 and 11 give `mf_plus1`=5 and `tb_div`=4. Code 10 gives `mf_plus1`=1 and `tb_div`=16.
- R5: While `por` is high the override fields load their defaults: `rt_src` = `strap_src`, `rt_slow` = 0 for code 00 and 1 otherwise, `tb_src` = 0 and `sys_div` = 00.
- R6: A `wr_en` pulse with both resets low loads all four fields from the `wr_*` inputs, visible from the next cycle. Without `wr_en` the fields hold. `rt_div` reads 512 when `rt_slow` is 1 and 4 when it is 0.
- R7: `rt_en` is a one-cycle pulse after every `rt_div`-th tick of the selected timer source (`rt_src` 1 = `ext_tick`, 0 = `osc_tick`). A source that does not tick produces no pulses.
- R8: `tb_en` is a one-cycle pulse after every `tb_div`-th tick of the selected timebase source (`tb_src` 0 = `pll_tick`, 1 = `gclk2_tick`).
- R9: When a divide ratio changes, its counter restarts from zero. With a tick on every cycle, the first pulse after a write that changes `rt_div` from 512 to 4 appears 5 cycles after the write edge, and none appears before it.
- R10: While `por` or `hrst` is high, both enables are low and both counters are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| hrst | input | 1 | Hard reset, active high, synchronous |
| strap_src | input | 1 | Reference source strap |
| strap_freq | input | 1 | Reference frequency strap |
| wr_en | input | 1 | Override field write strobe |
| wr_rt_src | input | 1 | New timer clock source |
| wr_rt_slow | input | 1 | New timer divide select (1 = 512) |
| wr_tb_src | input | 1 | New timebase source |
| wr_sys_div | input | 2 | New system clock divider |
| osc_tick | input | 1 | Oscillator tick |
| ext_tick | input | 1 | External clock tick |
| pll_tick | input | 1 | PLL-derived clock tick |
| gclk2_tick | input | 1 | Secondary system clock tick |
| ref_is_ext | output | 1 | Captured reference source |
| ref_is_4m | output | 1 | Captured reference frequency |
| mf_plus1 | output | 10 | Power-on multiplier plus one |
| rt_src | output | 1 | Timer clock source field |
| rt_slow | output | 1 | Timer divide select field |
| rt_div | output | 10 | Timer divide ratio in effect |
| tb_src | output | 1 | Timebase source field |
| tb_div | output | 5 | Timebase divide ratio |
| sys_div | output | 2 | System clock divider field |
| rt_en | output | 1 | Divided timer clock enable |
| tb_en | output | 1 | Divided timebase enable |

## Verification
The bench builds the block with the package's default widths: a 10-bit multiplier, a 10-bit timer ratio and a 5-bit timebase ratio. These widths hold the full 513/512/16 table, and each of the four strap codes is reached through its own power-on sequence. Because the ticks can be driven on every cycle, even the 512 divide and its half-rate variant fit in a short run. The restart check can therefore count the exact cycle of the first pulse after a ratio change.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int MF_W      = 10;
    localparam int RT_DIV_W  = 10;
    localparam int TB_DIV_W  = 5;
    localparam int SYS_DIV_W = 2;

    localparam logic [MF_W-1:0]     MF_OSC32    = MF_W'(513);
    localparam logic [MF_W-1:0]     MF_REF4M    = MF_W'(5);
    localparam logic [MF_W-1:0]     MF_ONE2ONE  = MF_W'(1);
    localparam logic [RT_DIV_W-1:0] RT_FAST     = RT_DIV_W'(4);
    localparam logic [RT_DIV_W-1:0] RT_SLOW     = RT_DIV_W'(512);
    localparam logic [TB_DIV_W-1:0] TB_NORMAL   = TB_DIV_W'(4);
    localparam logic [TB_DIV_W-1:0] TB_ONE2ONE  = TB_DIV_W'(16);

    typedef enum logic [1:0] {
        STRAP_OSC32   = 2'b00,
        STRAP_OSC4M   = 2'b01,
        STRAP_EXT1TO1 = 2'b10,
        STRAP_EXT4M   = 2'b11
    } strap_code_e;

    typedef struct packed {
        logic [MF_W-1:0]     mf_plus1;
        logic [TB_DIV_W-1:0] tb_div;
    } por_dflt_t;

    typedef struct packed {
        logic                 rt_src;
        logic                 rt_slow;
        logic                 tb_src;
        logic [SYS_DIV_W-1:0] sys_div;
    } ovr_t;

    function automatic por_dflt_t decode_straps(input strap_code_e code);
        por_dflt_t d;
        case (code)
            STRAP_OSC32: begin
                d.mf_plus1 = MF_OSC32;
                d.tb_div   = TB_NORMAL;
            end
            STRAP_EXT1TO1: begin
                d.mf_plus1 = MF_ONE2ONE;
                d.tb_div   = TB_ONE2ONE;
            end
            default: begin
                d.mf_plus1 = MF_REF4M;
                d.tb_div   = TB_NORMAL;
            end
        endcase
        return d;
    endfunction

    function automatic logic default_rt_slow(input strap_code_e code);
        return code != STRAP_OSC32;
    endfunction

endpackage

// File: rtl/clkcfg_strap_latch.sv
module clkcfg_strap_latch
    import clkcfg_pkg::*;
(
    input  logic        clk,
    input  logic        por,
    input  strap_code_e code_in,
    output strap_code_e code_q
);

    always_ff @(posedge clk) begin
        if (por) begin
            code_q <= code_in;
        end
    end

endmodule

// File: rtl/clkcfg_ovr_regs.sv
module clkcfg_ovr_regs
    import clkcfg_pkg::*;
(
    input  logic clk,
    input  logic por,
    input  logic hrst,
    input  ovr_t dflt,
    input  logic wr_en,
    input  ovr_t wdata,
    output ovr_t q
);

    always_ff @(posedge clk) begin
        if (por) begin
            q <= dflt;
        end else if (wr_en && !hrst) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/clkcfg_tick_div.sv
module clkcfg_tick_div #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic [W-1:0] ratio_q;
    logic         at_end;

    assign at_end = (cnt == ratio - ONE);

    always_ff @(posedge clk) begin
        ratio_q <= ratio;
        if (rst) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (ratio != ratio_q) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (tick) begin
            if (at_end) begin
                cnt   <= '0;
                pulse <= 1'b1;
            end else begin
                cnt   <= cnt + ONE;
                pulse <= 1'b0;
            end
        end else begin
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
    import clkcfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 por,
    input  logic                 hrst,
    input  logic                 strap_src,
    input  logic                 strap_freq,
    input  logic                 wr_en,
    input  logic                 wr_rt_src,
    input  logic                 wr_rt_slow,
    input  logic                 wr_tb_src,
    input  logic [SYS_DIV_W-1:0] wr_sys_div,
    input  logic                 osc_tick,
    input  logic                 ext_tick,
    input  logic                 pll_tick,
    input  logic                 gclk2_tick,
    output logic                 ref_is_ext,
    output logic                 ref_is_4m,
    output logic [MF_W-1:0]      mf_plus1,
    output logic                 rt_src,
    output logic                 rt_slow,
    output logic [RT_DIV_W-1:0]  rt_div,
    output logic                 tb_src,
    output logic [TB_DIV_W-1:0]  tb_div,
    output logic [SYS_DIV_W-1:0] sys_div,
    output logic                 rt_en,
    output logic                 tb_en
);

    strap_code_e code_live;
    strap_code_e code_q;
    por_dflt_t   dflt_q;
    ovr_t        ovr_dflt;
    ovr_t        ovr_wdata;
    ovr_t        ovr_q;
    logic        div_rst;
    logic        rt_tick;
    logic        tb_tick;

    assign code_live = strap_code_e'({strap_src, strap_freq});

    clkcfg_strap_latch u_latch (
        .clk     (clk),
        .por     (por),
        .code_in (code_live),
        .code_q  (code_q)
    );

    assign dflt_q = decode_straps(code_q);

    assign ovr_dflt = '{rt_src:  strap_src,
                        rt_slow: default_rt_slow(code_live),
                        tb_src:  1'b0,
                        sys_div: '0};

    assign ovr_wdata = '{rt_src:  wr_rt_src,
                         rt_slow: wr_rt_slow,
                         tb_src:  wr_tb_src,
                         sys_div: wr_sys_div};

    clkcfg_ovr_regs u_regs (
        .clk   (clk),
        .por   (por),
        .hrst  (hrst),
        .dflt  (ovr_dflt),
        .wr_en (wr_en),
        .wdata (ovr_wdata),
        .q     (ovr_q)
    );

    assign div_rst = por | hrst;
    assign rt_tick = ovr_q.rt_src ? ext_tick : osc_tick;
    assign tb_tick = ovr_q.tb_src ? gclk2_tick : pll_tick;
    assign rt_div  = ovr_q.rt_slow ? RT_SLOW : RT_FAST;

    clkcfg_tick_div #(.W(RT_DIV_W)) u_rt_div (
        .clk   (clk),
        .rst   (div_rst),
        .tick  (rt_tick),
        .ratio (rt_div),
        .pulse (rt_en)
    );

    clkcfg_tick_div #(.W(TB_DIV_W)) u_tb_div (
        .clk   (clk),
        .rst   (div_rst),
        .tick  (tb_tick),
        .ratio (tb_div),
        .pulse (tb_en)
    );

    assign ref_is_ext = code_q[1];
    assign ref_is_4m  = code_q[0];
    assign mf_plus1   = dflt_q.mf_plus1;
    assign tb_div     = dflt_q.tb_div;
    assign rt_src     = ovr_q.rt_src;
    assign rt_slow    = ovr_q.rt_slow;
    assign tb_src     = ovr_q.tb_src;
    assign sys_div    = ovr_q.sys_div;

endmodule

// File: rtl/clkcfg_ctrl_chk.sv
module clkcfg_ctrl_chk
    import clkcfg_pkg::*;
(
    input logic                 clk,
    input logic                 por,
    input logic                 hrst,
    input logic                 wr_en,
    input logic                 ref_is_ext,
    input logic                 ref_is_4m,
    input logic [MF_W-1:0]      mf_plus1,
    input logic                 rt_src,
    input logic                 rt_slow,
    input logic                 tb_src,
    input logic [TB_DIV_W-1:0]  tb_div,
    input logic [SYS_DIV_W-1:0] sys_div,
    input logic                 rt_en,
    input logic                 tb_en
);

    logic por_seen = 1'b0;

    always_ff @(posedge clk) begin
        if (por) begin
            por_seen <= 1'b1;
        end
    end

    AST_STRAP_KEPT: assert property (@(posedge clk) disable iff (por || !por_seen)
        !$past(por) |-> ($stable(mf_plus1) && $stable(tb_div) && $stable(ref_is_ext) && $stable(ref_is_4m))); // R1

    AST_HRST_FIELDS: assert property (@(posedge clk) disable iff (por || !por_seen)
        hrst |=> ($stable(rt_src) && $stable(rt_slow) && $stable(tb_src) && $stable(sys_div))); // R2

    AST_ONE2ONE_CODE: assert property (@(posedge clk) disable iff (por || !por_seen)
        (ref_is_ext && !ref_is_4m) |-> (mf_plus1 == MF_W'(1) && tb_div == TB_DIV_W'(16))); // R4

    AST_REF4M_CODE: assert property (@(posedge clk) disable iff (por || !por_seen)
        ref_is_4m |-> (mf_plus1 == MF_W'(5) && tb_div == TB_DIV_W'(4))); // R4

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (por || !por_seen)
        !wr_en |=> ($stable(rt_src) && $stable(rt_slow) && $stable(tb_src) && $stable(sys_div))); // R6

    AST_RT_SINGLE: assert property (@(posedge clk) disable iff (por || !por_seen)
        rt_en |=> !rt_en); // R7

    AST_TB_SINGLE: assert property (@(posedge clk) disable iff (por || !por_seen)
        tb_en |=> !tb_en); // R8

    AST_EN_QUIET: assert property (@(posedge clk) disable iff (!por_seen)
        (por || hrst) |=> (!rt_en && !tb_en)); // R10

endmodule

bind clkcfg_ctrl clkcfg_ctrl_chk u_chk (
    .clk        (clk),
    .por        (por),
    .hrst       (hrst),
    .wr_en      (wr_en),
    .ref_is_ext (ref_is_ext),
    .ref_is_4m  (ref_is_4m),
    .mf_plus1   (mf_plus1),
    .rt_src     (rt_src),
    .rt_slow    (rt_slow),
    .tb_src     (tb_src),
    .tb_div     (tb_div),
    .sys_div    (sys_div),
    .rt_en      (rt_en),
    .tb_en      (tb_en)
);

// File: tb/clkcfg_ctrl_test.sv
`timescale 1ns/1ps
module clkcfg_ctrl_test;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       hrst = 1'b0;
    logic       strap_src = 1'b0;
    logic       strap_freq = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_rt_src = 1'b0;
    logic       wr_rt_slow = 1'b0;
    logic       wr_tb_src = 1'b0;
    logic [1:0] wr_sys_div = 2'b00;
    logic       osc_tick = 1'b0;
    logic       ext_tick = 1'b0;
    logic       pll_tick = 1'b0;
    logic       gclk2_tick = 1'b0;
    logic       ref_is_ext, ref_is_4m, rt_src, rt_slow, tb_src, rt_en, tb_en;
    logic [9:0] mf_plus1, rt_div;
    logic [4:0] tb_div;
    logic [1:0] sys_div;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  half_rate = 1'b0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (half_rate) ext_tick <= ~ext_tick;
    end

    clkcfg_ctrl uut (
        .clk(clk), .por(por), .hrst(hrst),
        .strap_src(strap_src), .strap_freq(strap_freq),
        .wr_en(wr_en), .wr_rt_src(wr_rt_src), .wr_rt_slow(wr_rt_slow),
        .wr_tb_src(wr_tb_src), .wr_sys_div(wr_sys_div),
        .osc_tick(osc_tick), .ext_tick(ext_tick), .pll_tick(pll_tick), .gclk2_tick(gclk2_tick),
        .ref_is_ext(ref_is_ext), .ref_is_4m(ref_is_4m), .mf_plus1(mf_plus1),
        .rt_src(rt_src), .rt_slow(rt_slow), .rt_div(rt_div), .tb_src(tb_src),
        .tb_div(tb_div), .sys_div(sys_div), .rt_en(rt_en), .tb_en(tb_en)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_mf(input logic [1:0] c);
        return (c == 2'b00) ? 513 : (c == 2'b10) ? 1 : 5;
    endfunction
    function automatic int exp_tb(input logic [1:0] c);
        return (c == 2'b10) ? 16 : 4;
    endfunction
    function automatic int exp_rt(input logic [1:0] c);
        return (c == 2'b00) ? 4 : 512;
    endfunction

    task automatic do_por(input logic [1:0] early, input logic [1:0] last, input logic [1:0] after);
        @(negedge clk);
        por = 1'b1; hrst = 1'b0;
        {strap_src, strap_freq} = early;
        repeat (3) @(negedge clk);
        check("R10", "rt_en during por", int'(rt_en), 0);
        check("R10", "tb_en during por", int'(tb_en), 0);
        {strap_src, strap_freq} = last;
        @(negedge clk);
        por = 1'b0;
        {strap_src, strap_freq} = after;
        @(negedge clk);
    endtask

    task automatic check_defaults(input logic [1:0] c);
        check("R1", "mf_plus1 from last por code", int'(mf_plus1), exp_mf(c));
        check("R4", "tb_div", int'(tb_div), exp_tb(c));
        check("R3", "ref_is_ext", int'(ref_is_ext), int'(c[1]));
        check("R3", "ref_is_4m", int'(ref_is_4m), int'(c[0]));
        check("R5", "rt_src default", int'(rt_src), int'(c[1]));
        check("R5", "rt_div default", int'(rt_div), exp_rt(c));
        check("R5", "tb_src default", int'(tb_src), 0);
        check("R5", "sys_div default", int'(sys_div), 0);
    endtask

    task automatic write_fields(input logic s, input logic sl, input logic t, input logic [1:0] d);
        wr_en = 1'b1; wr_rt_src = s; wr_rt_slow = sl; wr_tb_src = t; wr_sys_div = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic gap(input bit use_tb, output int g);
        int n = 0;
        while (!(use_tb ? tb_en : rt_en) && n < 3000) begin
            @(negedge clk); n++;
        end
        g = 0;
        do begin
            @(negedge clk); g++;
        end while (!(use_tb ? tb_en : rt_en) && g < 3000);
    endtask

    task automatic count_pulses(input bit use_tb, input int cycles, output int p);
        p = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (use_tb ? tb_en : rt_en) p++;
        end
    endtask

    task automatic t_reset_code00;
        do_por(2'b11, 2'b00, 2'b11);
        check_defaults(2'b00);
    endtask

    task automatic t_periods_code00;
        int g;
        osc_tick = 1; ext_tick = 1; pll_tick = 1; gclk2_tick = 1;
        gap(1'b0, g); check("R7", "rt gap div4", g, 4);
        gap(1'b1, g); check("R8", "tb gap div4", g, 4);
    endtask

    task automatic t_write_hrst;
        int p;
        write_fields(1'b1, 1'b1, 1'b1, 2'b11);
        check("R6", "rt_src written", int'(rt_src), 1);
        check("R6", "rt_div written", int'(rt_div), 512);
        check("R6", "tb_src written", int'(tb_src), 1);
        check("R6", "sys_div written", int'(sys_div), 3);
        {strap_src, strap_freq} = 2'b10;
        hrst = 1'b1;
        wr_en = 1'b1; wr_rt_src = 0; wr_rt_slow = 0; wr_tb_src = 0; wr_sys_div = 2'b01;
        p = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rt_en || tb_en) p++;
        end
        check("R10", "enables during hrst", p, 0);
        hrst = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        check("R2", "mf_plus1 after hrst", int'(mf_plus1), 513);
        check("R2", "tb_div after hrst", int'(tb_div), 4);
        check("R2", "ref_is_ext after hrst", int'(ref_is_ext), 0);
        check("R2", "rt_src after hrst", int'(rt_src), 1);
        check("R2", "rt_slow after hrst", int'(rt_slow), 1);
        check("R2", "tb_src after hrst", int'(tb_src), 1);
        check("R2", "sys_div after hrst", int'(sys_div), 3);
    endtask

    task automatic t_source_select;
        int g, p;
        pll_tick = 0; gclk2_tick = 1;
        gap(1'b1, g); check("R8", "tb gap on gclk2", g, 4);
        pll_tick = 1; gclk2_tick = 0;
        repeat (3) @(negedge clk);
        count_pulses(1'b1, 30, p); check("R8", "tb pulses with idle gclk2", p, 0);
        osc_tick = 0; ext_tick = 1;
        gap(1'b0, g); check("R7", "rt gap on ext div512", g, 512);
        ext_tick = 0; osc_tick = 1;
        repeat (3) @(negedge clk);
        count_pulses(1'b0, 600, p); check("R7", "rt pulses with idle ext", p, 0);
        half_rate = 1'b1;
        gap(1'b0, g); check("R7", "rt gap half-rate ext", g, 1024);
        half_rate = 1'b0;
        @(negedge clk);
        ext_tick = 1;
    endtask

    task automatic t_code10;
        int g;
        do_por(2'b00, 2'b10, 2'b01);
        check_defaults(2'b10);
        osc_tick = 0; ext_tick = 1; pll_tick = 1;
        gap(1'b0, g); check("R7", "rt gap code10 ext", g, 512);
        gap(1'b1, g); check("R8", "tb gap div16", g, 16);
        osc_tick = 1;
    endtask

    task automatic t_code01_restart;
        int first;
        do_por(2'b10, 2'b01, 2'b00);
        check_defaults(2'b01);
        osc_tick = 1; ext_tick = 0;
        repeat (100) @(negedge clk);
        write_fields(1'b0, 1'b0, 1'b0, 2'b00);
        first = 0;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (rt_en && first == 0) first = k;
        end
        check("R9", "first pulse after ratio change", first, 5);
        ext_tick = 1;
    endtask

    task automatic t_code11;
        do_por(2'b01, 2'b11, 2'b10);
        check_defaults(2'b11);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset_code00();
        t_periods_code00();
        t_write_hrst();
        t_source_select();
        t_code10();
        t_code01_restart();
        t_code11();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule